// File: doc/BRIEF.md
# Windowed Parallel Control Register Bank

This block holds a bank of byte-wide control registers. The whole bank is driven out as one flat vector, so any logic elsewhere on the chip can read any register in any cycle without a read port. Software or a debug path writes it one byte at a time through a port with an 8-bit data bus, a 20-bit address and a write enable.

A write takes effect only when the upper address bits match a base-window parameter. The window is 256 bytes for banks of up to 256 registers. For larger banks it widens to the next power of two, and the compare drops its lowest bits to match. Every input is first captured in a register, and that includes reset. The bank uses the captured reset, which eases timing when the block runs on a slower clock. On reset, the lowest 32 bytes load per-byte parameter values and all higher bytes clear to zero.

Top module: `ctrl_reg_bank`

## Requirements
- R1: Register n of the bank is presented on `regs_o[8n+7:8n]`. All registers are visible at the same time.
- R2: A write presented at a clock edge is captured at that edge and becomes visible on `regs_o` after the next edge. It is unchanged after the first edge and updated after the second. Writes on consecutive cycles all land.
- R3: For banks of at most 256 bytes, a write lands only when `wr_addr_i[19:8]` equals `BASE_ADDR`. Register `wr_addr_i[7:0]` is selected. The default `BASE_ADDR` is 12'hFFF, the top 256 bytes of the 20-bit space.
- R4: For banks larger than 256 bytes, the window is 2^k bytes, with k = ceil(log2(HW_REGS_SIZE)). Only `wr_addr_i[19:k]` is compared with `BASE_ADDR[11:k-8]`, and `wr_addr_i[k-1:0]` selects the register. For 384 bytes this means k = 9 and bit 8 is ignored.
- R5: A write inside the window whose offset is HW_REGS_SIZE or greater changes no register. Offset HW_REGS_SIZE-1 is still writable.
- R6: After reset, register n for n < 32 holds byte n of `RST_BYTES`, and every register from 32 upward holds 0.
- R7: `rst_i` is registered before use. It reaches the bank one clock later, so an asserted reset changes `regs_o` after the second edge, not the first.
- R8: Reset takes priority over a write captured in the same cycle; the result is the reset image.
- R9: With `wr_en_i` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset, registered before use |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 20 | Write byte address |
| wr_data_i | input | 8 | Write data byte |
| regs_o | output | HW_REGS_SIZE*8 | Whole register bank, register n at bits 8n+7:8n |

## Verification
Several properties are checked on every cycle:
- the captured reset follows the input by one clock;
- the decoded select is one-hot or idle;
- a decoded hit never names an offset beyond the bank;
- every accepted write appears in its byte one edge after capture;
- the bank stays stable when nothing is accepted;
- the reset image appears after every captured reset.

Other behaviours need the bench's scenarios, because they depend on what the address was rather than on what the decoder did:
- which addresses lie in or out of the window;
- the ignored window bit of the 384-byte bank;
- the offset boundary at the top of a partial bank;
- reset winning over a simultaneous write, as seen at the ports.

// File: rtl/ctrl_regs_pkg.sv
package ctrl_regs_pkg;

    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 8;
    localparam int BASE_W     = 12;
    localparam int INIT_COUNT = 32;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // lowest address bit that takes part in the window compare
    function automatic int win_lsb(int size);
        return (size > 256) ? $clog2(size) : 8;
    endfunction

endpackage

// File: rtl/ctrl_regs_capture.sv
module ctrl_regs_capture
    import ctrl_regs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              rst_q,
    output wr_req_t           req_q
);

    // every input, reset included, passes through one flop
    always_ff @(posedge clk_i) begin
        rst_q      <= rst_i;
        req_q.we   <= wr_en_i;
        req_q.addr <= wr_addr_i;
        req_q.data <= wr_data_i;
    end

endmodule

// File: rtl/ctrl_regs_decode.sv
module ctrl_regs_decode
    import ctrl_regs_pkg::*;
#(
    parameter int                HW_REGS_SIZE = 256,
    parameter logic [BASE_W-1:0] BASE_ADDR    = 12'hFFF,
    localparam int               OFF_W        = win_lsb(HW_REGS_SIZE)
)(
    input  wr_req_t                 req,
    output logic                    hit,
    output logic [OFF_W-1:0]        off,
    output logic [HW_REGS_SIZE-1:0] sel
);

    logic win_match;
    logic in_range;

    assign off       = req.addr[OFF_W-1:0];
    assign win_match = (req.addr[ADDR_W-1:OFF_W] == BASE_ADDR[BASE_W-1:OFF_W-8]);

    generate
        if (HW_REGS_SIZE == (1 << OFF_W)) begin : g_full_win
            assign in_range = 1'b1;
        end else begin : g_part_win
            assign in_range = (int'(off) < HW_REGS_SIZE);
        end
    endgenerate

    assign hit = req.we && win_match && in_range;

    generate
        for (genvar n = 0; n < HW_REGS_SIZE; n++) begin : g_sel
            assign sel[n] = hit && (off == OFF_W'(n));
        end
    endgenerate

endmodule

// File: rtl/ctrl_regs_store.sv
module ctrl_regs_store
    import ctrl_regs_pkg::*;
#(
    parameter int                              HW_REGS_SIZE = 256,
    parameter logic [INIT_COUNT-1:0][DATA_W-1:0] RST_BYTES  = '0
)(
    input  logic                           clk_i,
    input  logic                           rst_q,
    input  logic [HW_REGS_SIZE-1:0]        sel,
    input  logic [DATA_W-1:0]              wdata,
    output logic [HW_REGS_SIZE*DATA_W-1:0] regs_o
);

    generate
        for (genvar n = 0; n < HW_REGS_SIZE; n++) begin : g_byte
            if (n < INIT_COUNT) begin : g_preset
                always_ff @(posedge clk_i) begin
                    if (rst_q)
                        regs_o[n*DATA_W +: DATA_W] <= RST_BYTES[n];
                    else if (sel[n])
                        regs_o[n*DATA_W +: DATA_W] <= wdata;
                end
            end else begin : g_zero
                always_ff @(posedge clk_i) begin
                    if (rst_q)
                        regs_o[n*DATA_W +: DATA_W] <= '0;
                    else if (sel[n])
                        regs_o[n*DATA_W +: DATA_W] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import ctrl_regs_pkg::*;
#(
    parameter int                                HW_REGS_SIZE = 256,
    parameter logic [BASE_W-1:0]                 BASE_ADDR    = 12'hFFF,
    parameter logic [INIT_COUNT-1:0][DATA_W-1:0] RST_BYTES    = '0
)(
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           wr_en_i,
    input  logic [19:0]                    wr_addr_i,
    input  logic [7:0]                     wr_data_i,
    output logic [HW_REGS_SIZE*8-1:0]      regs_o
);

    localparam int OFF_W = win_lsb(HW_REGS_SIZE);

    logic                    rst_q;
    wr_req_t                 req_q;
    logic                    hit;
    logic [OFF_W-1:0]        off;
    logic [HW_REGS_SIZE-1:0] sel;

    ctrl_regs_capture u_capture (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rst_q     (rst_q),
        .req_q     (req_q)
    );

    ctrl_regs_decode #(
        .HW_REGS_SIZE (HW_REGS_SIZE),
        .BASE_ADDR    (BASE_ADDR)
    ) u_decode (
        .req (req_q),
        .hit (hit),
        .off (off),
        .sel (sel)
    );

    ctrl_regs_store #(
        .HW_REGS_SIZE (HW_REGS_SIZE),
        .RST_BYTES    (RST_BYTES)
    ) u_store (
        .clk_i  (clk_i),
        .rst_q  (rst_q),
        .sel    (sel),
        .wdata  (req_q.data),
        .regs_o (regs_o)
    );

endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk
    import ctrl_regs_pkg::*;
#(
    parameter int                                HW_REGS_SIZE = 256,
    parameter logic [INIT_COUNT-1:0][DATA_W-1:0] RST_BYTES    = '0,
    localparam int                               OFF_W        = win_lsb(HW_REGS_SIZE)
)(
    input logic                      clk_i,
    input logic                      rst_i,
    input logic                      rst_q,
    input logic                      hit,
    input logic [OFF_W-1:0]          off,
    input logic [HW_REGS_SIZE-1:0]   sel,
    input logic [7:0]                wdata,
    input logic [HW_REGS_SIZE*8-1:0] regs_o
);

    function automatic logic [HW_REGS_SIZE*8-1:0] reset_image();
        logic [HW_REGS_SIZE*8-1:0] v;
        v = '0;
        for (int n = 0; n < INIT_COUNT && n < HW_REGS_SIZE; n++)
            v[n*8 +: 8] = RST_BYTES[n];
        return v;
    endfunction

    localparam logic [HW_REGS_SIZE*8-1:0] IMG = reset_image();

    logic [OFF_W-1:0] last_off;
    logic [7:0]       last_data;

    always_ff @(posedge clk_i) begin
        last_off  <= off;
        last_data <= wdata;
    end

    // R7
    rst_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_q == $past(rst_i));

    // R6
    reset_image_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_q |=> (regs_o == IMG));

    // R5
    hit_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hit |-> (int'(off) < HW_REGS_SIZE));

    // R3
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(sel));

    // R2
    write_lands_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
        hit |=> (regs_o[int'(last_off)*8 +: 8] == last_data));

    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || rst_q)
        !hit |=> $stable(regs_o));

endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(
    .HW_REGS_SIZE (HW_REGS_SIZE),
    .RST_BYTES    (RST_BYTES)
) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .rst_q  (rst_q),
    .hit    (hit),
    .off    (off),
    .sel    (sel),
    .wdata  (req_q.data),
    .regs_o (regs_o)
);

// File: tb/ctrl_reg_bank_tb_top.sv
module ctrl_reg_bank_tb_top;

    localparam int          NS   = 256;
    localparam int          WS   = 384;
    localparam logic [11:0] BASE = 12'hFFF;

    function automatic logic [31:0][7:0] mk_init();
        logic [31:0][7:0] v;
        for (int k = 0; k < 32; k++) v[k] = 8'h5A ^ 8'(k * 7 + 1);
        return v;
    endfunction

    localparam logic [31:0][7:0] INIT = mk_init();

    logic          clk = 1'b0;
    logic          rst;
    logic          we;
    logic [19:0]   addr;
    logic [7:0]    data;
    logic [NS*8-1:0] n_regs;
    logic [WS*8-1:0] w_regs;

    ctrl_reg_bank #(.HW_REGS_SIZE(NS), .BASE_ADDR(BASE), .RST_BYTES(INIT)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(we), .wr_addr_i(addr),
        .wr_data_i(data), .regs_o(n_regs));

    ctrl_reg_bank #(.HW_REGS_SIZE(WS), .BASE_ADDR(BASE), .RST_BYTES(INIT)) dut_wide_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(we), .wr_addr_i(addr),
        .wr_data_i(data), .regs_o(w_regs));

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference: byte arrays plus a one-stage input queue
    logic [7:0] mn [NS];
    logic [7:0] mw [WS];
    bit         mvalid = 0;
    logic       p_rst = 1'b0, p_we = 1'b0;
    logic [19:0] p_addr = '0;
    logic [7:0]  p_data = '0;

    function automatic bit in_win(int size, logic [19:0] a, output int o);
        int lsb;
        int span;
        lsb  = (size > 256) ? $clog2(size) : 8;
        span = 1 << lsb;
        o    = int'(a) % span;
        return ((int'(a) / span) == (int'(BASE) * 256 / span)) && (o < size);
    endfunction

    always @(posedge clk) begin
        int o;
        if (p_rst) begin
            for (int k = 0; k < NS; k++) mn[k] = (k < 32) ? INIT[k] : 8'h00;
            for (int k = 0; k < WS; k++) mw[k] = (k < 32) ? INIT[k] : 8'h00;
            mvalid = 1;
        end else if (p_we) begin
            if (in_win(NS, p_addr, o)) mn[o] = p_data;
            if (in_win(WS, p_addr, o)) mw[o] = p_data;
        end
        p_rst  = rst;
        p_we   = we;
        p_addr = addr;
        p_data = data;
    end

    // R1: every byte lane compared against the model each cycle
    always @(negedge clk) begin
        if (mvalid && !done) begin
            bit ok;
            ok = 1;
            total++;
            for (int k = 0; k < NS; k++)
                if (ok && n_regs[k*8 +: 8] !== mn[k]) begin
                    ok = 0;
                    $display("FAIL R1 narrow byte %0d got=%h exp=%h", k, n_regs[k*8 +: 8], mn[k]);
                end
            for (int k = 0; k < WS; k++)
                if (ok && w_regs[k*8 +: 8] !== mw[k]) begin
                    ok = 0;
                    $display("FAIL R1 wide byte %0d got=%h exp=%h", k, w_regs[k*8 +: 8], mw[k]);
                end
            if (!ok) bad++;
        end
    end

    function automatic logic [7:0] nb(int i);
        return n_regs[i*8 +: 8];
    endfunction

    function automatic logic [7:0] wb(int i);
        return w_regs[i*8 +: 8];
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // presents one write for one cycle; returns after the capture edge
    task automatic wr(logic [19:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [WS*8-1:0] snap;
        rst = 1'b1; we = 1'b0; addr = '0; data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R6 reset image
        chk("R6 byte0", nb(0), INIT[0]);
        chk("R6 byte31", nb(31), INIT[31]);
        chk("R6 byte32", nb(32), 8'h00);
        chk("R6 wide byte383", wb(383), 8'h00);

        // R2 latency, R1 lane position
        wr(20'hFFF05, 8'h3C);
        chk("R2 after capture edge", nb(5), INIT[5]);
        @(negedge clk);
        chk("R2 after update edge", nb(5), 8'h3C);
        chk("R1 lane 47:40", n_regs[47:40], 8'h3C);

        // R3 miss for narrow, R4 hit for wide (bit 8 ignored)
        wr(20'hFFE05, 8'h77);
        @(negedge clk);
        chk("R3 outside window", nb(5), 8'h3C);
        chk("R4 wide bit8 ignored", wb(5), 8'h77);
        chk("R4 wide offset 261", wb(261), 8'h3C);

        wr(20'h7FF05, 8'h11);
        @(negedge clk);
        chk("R3 far address", nb(5), 8'h3C);

        // R5 offset past the wide bank
        snap = w_regs;
        wr(20'hFFF80, 8'h99);
        @(negedge clk);
        total++;
        if (w_regs !== snap) begin
            bad++;
            $display("FAIL R5 wide bank changed got=%h exp=%h", w_regs[383*8 +: 8], snap[383*8 +: 8]);
        end
        chk("R3 narrow byte128", nb(128), 8'h99);
        wr(20'hFFF7F, 8'h42);
        @(negedge clk);
        chk("R5 wide top byte", wb(383), 8'h42);

        // R9 enable low
        @(negedge clk);
        addr = 20'hFFF10; data = 8'hEE; we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 no enable", nb(16), INIT[16]);

        // R2 back-to-back
        @(negedge clk);
        addr = 20'hFFFC8; data = 8'hD1; we = 1'b1;
        @(negedge clk);
        addr = 20'hFFFC9; data = 8'hD2;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        chk("R2 back-to-back 200", nb(200), 8'hD1);
        chk("R2 back-to-back 201", nb(201), 8'hD2);

        // R8 reset with simultaneous write
        @(negedge clk);
        rst = 1'b1; addr = 20'hFFF00; data = 8'hFF; we = 1'b1;
        @(negedge clk);
        rst = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R8 reset wins", nb(0), INIT[0]);
        chk("R8 earlier write cleared", nb(5), INIT[5]);

        // R7 reset registered
        wr(20'hFFF28, 8'hAB);
        @(negedge clk);
        chk("R7 setup byte40", nb(40), 8'hAB);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 one edge after reset", nb(40), 8'hAB);
        @(negedge clk);
        chk("R7 two edges after reset", nb(40), 8'h00);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule